// File: doc/BRIEF.md
# Coprocessor System Register Access Decoder

This block sits beside a processor core and serves coprocessor move instructions routed to one system coprocessor. It pulls the operation fields out of the 32-bit instruction word and matches them against two system registers. It then checks whether the current privilege level may reach the selected register. It either returns read data with the destination register index, accepts a write, or flags the instruction as undefined so that the core takes the undefined-instruction exception.

There are two registers. The first is a one-bit environment control register. The second is a full-width handler base register. When the control bit is set, user-mode code can no longer reach the handler base register. Privileged code can always reach it. When a write flips the control bit, a single-cycle pulse tells downstream logic that cached decode state is stale.

Decode and trap results are combinational from a valid-qualified request. Register updates land on the next rising clock edge and only for a request that did not trap. The core is assumed to route only instructions for this coprocessor to the block.

Top module: `cpreg_access_unit`

## Requirements
- R1: On an accepted read, `rd_index` equals instruction bits [15:12]. It is zero whenever `rd_valid` is low.
- R2: Instruction bit 20 high means a read (`rd_valid` asserted, `wr_strobe` low). Bit 20 low means a write (`wr_strobe` asserted, `rd_valid` low). This holds only for accepted requests.
- R3: The control register is selected by bits [23:21]=6, [19:16]=0, [7:5]=0 and [3:0]=0. The handler base register uses the same values except [19:16]=1. Any other combination asserts `undef`.
- R4: Any user-mode (`user_mode`=1) read or write of the control register asserts `undef`.
- R5: A user-mode access to the handler base register asserts `undef` exactly when the stored control bit is 1. Privileged access never traps.
- R6: A write to the control register stores only bit 0 of `wr_value`. A read of it returns that bit in bit 0, with bits [31:1] zero.
- R7: With `feat_en` low, every valid request asserts `undef`.
- R8: `ctrl_change` is high during an accepted control write whose bit 0 differs from the stored bit. It is low for a write of the same value and at all other times.
- R9: A write to the handler base register stores all 32 bits, and later reads return them unchanged.
- R10: While `rst_n` is low at a rising edge, both registers are cleared to zero (synchronous, active-low).
- R11: A trapped request changes neither register and asserts neither `rd_valid` nor `wr_strobe`. With `req_valid` low, all outputs are low and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Coprocessor move instruction word |
| user_mode | input | 1 | 1 = unprivileged, 0 = privileged |
| feat_en | input | 1 | Feature strap; 0 makes every access undefined |
| wr_value | input | 32 | Source register value for writes |
| rd_valid | output | 1 | Accepted read; `rd_data` and `rd_index` are meaningful |
| rd_data | output | 32 | Value read from the selected register |
| rd_index | output | 4 | Destination register number for the read |
| wr_strobe | output | 1 | Accepted write; committed at the next rising edge |
| undef | output | 1 | Undefined-instruction flag |
| ctrl_change | output | 1 | Control bit is about to change; invalidate cached state |

## Verification
A corrupted control bit shows up at the ports in two ways. User-mode handler base accesses trap when they should not, or pass when they should trap. It also shows on the very next read of the control register, one cycle after the bad write. A missing or spurious change pulse is visible in the same cycle as the write. A wrong handler base value is visible on the next read. The random stream mixes privilege levels, strap values and near-miss encodings with a bench-side register model, so each stored bit is checked soon after it is written.

// File: rtl/cpreg_pkg.sv
// Package: shared field layout, widths and selector type for the
// coprocessor system register access decoder.
// Assumes a 32-bit coprocessor move encoding with the field positions below.
package cpreg_pkg;

    localparam int INSTR_W  = 32;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 4;

    // field positions (lsb) and widths
    localparam int OPC1_LSB = 21;
    localparam int OPC1_W   = 3;
    localparam int DIR_BIT  = 20;
    localparam int CRN_LSB  = 16;
    localparam int CRN_W    = 4;
    localparam int RT_LSB   = 12;
    localparam int OPC2_LSB = 5;
    localparam int OPC2_W   = 3;
    localparam int CRM_LSB  = 0;
    localparam int CRM_W    = 4;

    // number of decoded registers
    localparam int NUM_REGS = 2;

    typedef struct packed {
        logic [OPC1_W-1:0] opc1;
        logic              is_read;
        logic [CRN_W-1:0]  crn;
        logic [IDX_W-1:0]  rt;
        logic [OPC2_W-1:0] opc2;
        logic [CRM_W-1:0]  crm;
    } cp_fields_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_BASE = 2'd2
    } reg_sel_t;

endpackage

// File: rtl/cpreg_field_decode.sv
// Module: cpreg_field_decode
// Splits the instruction into its operation fields and matches them against
// the register selectors. Purely combinational.
// Assumes only instructions for this coprocessor reach the block, so the
// coprocessor number and the remaining opcode bits are not examined.
module cpreg_field_decode
    import cpreg_pkg::*;
#(
    parameter logic [OPC1_W-1:0] MATCH_OPC1 = 3'd6,
    parameter logic [CRN_W-1:0]  CTRL_CRN   = 4'd0,
    parameter logic [CRN_W-1:0]  BASE_CRN   = 4'd1
) (
    input  logic [INSTR_W-1:0] instr,
    output cp_fields_t         fields,
    output reg_sel_t           sel
);

    localparam logic [CRN_W-1:0] SEL_CRN [NUM_REGS] = '{CTRL_CRN, BASE_CRN};

    logic [NUM_REGS-1:0] hit;
    logic                unused_bits;

    // slice the fixed field positions out of the word
    always_comb begin
        fields.opc1    = instr[OPC1_LSB +: OPC1_W];
        fields.is_read = instr[DIR_BIT];
        fields.crn     = instr[CRN_LSB +: CRN_W];
        fields.rt      = instr[RT_LSB +: IDX_W];
        fields.opc2    = instr[OPC2_LSB +: OPC2_W];
        fields.crm     = instr[CRM_LSB +: CRM_W];
    end

    assign unused_bits = ^{instr[INSTR_W-1:OPC1_LSB+OPC1_W],
                           instr[RT_LSB-1:OPC2_LSB+OPC2_W],
                           instr[OPC2_LSB-1:CRM_LSB+CRM_W]};

    // one comparator per decoded register
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
        assign hit[i] = (fields.opc1 == MATCH_OPC1) &&
                        (fields.crn  == SEL_CRN[i]) &&
                        (fields.crm  == '0) &&
                        (fields.opc2 == '0);
    end

    // turn the hit vector into a selector
    always_comb begin
        unique case (hit)
            2'b01:   sel = SEL_CTRL;
            2'b10:   sel = SEL_BASE;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/cpreg_access_check.sv
// Module: cpreg_access_check
// Applies the feature strap and the privilege rules to a decoded request.
// Produces the undefined flag and the accepted read/write enables.
// Assumes the control bit input is the currently stored value.
module cpreg_access_check
    import cpreg_pkg::*;
(
    input  logic     req_valid,
    input  logic     feat_en,
    input  logic     user_mode,
    input  logic     is_read,
    input  reg_sel_t sel,
    input  logic     ctrl_bit,
    output logic     undef,
    output logic     rd_ok,
    output logic     wr_ctrl,
    output logic     wr_base
);

    logic known;
    logic priv_fail;
    logic accept;

    // classify the request as illegal or accepted
    always_comb begin
        known     = (sel != SEL_NONE);
        priv_fail = user_mode &&
                    ((sel == SEL_CTRL) || ((sel == SEL_BASE) && ctrl_bit));
        undef     = req_valid && (!feat_en || !known || priv_fail);
        accept    = req_valid && feat_en && known && !priv_fail;
        rd_ok     = accept && is_read;
        wr_ctrl   = accept && !is_read && (sel == SEL_CTRL);
        wr_base   = accept && !is_read && (sel == SEL_BASE);
    end

endmodule

// File: rtl/cpreg_store.sv
// Module: cpreg_store
// Holds the one-bit control register and the handler base register.
// Flags a pending change of the control bit in the same cycle as the write.
// Assumes at most one of the write enables is high in a cycle.
module cpreg_store
    import cpreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_base,
    input  logic [DATA_W-1:0] wr_value,
    output logic              ctrl_q,
    output logic [DATA_W-1:0] base_q,
    output logic              ctrl_change
);

    // control bit storage, only bit 0 of the source is kept
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 1'b0;
        else if (wr_ctrl) ctrl_q <= wr_value[0];
    end

    // handler base storage, full width
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (wr_base) base_q <= wr_value;
    end

    // pulse only when the stored bit will actually flip
    assign ctrl_change = wr_ctrl && (wr_value[0] != ctrl_q);

    assert_change_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_change |=> (ctrl_q != $past(ctrl_q)));

    assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));

    assert_base_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_base |=> $stable(base_q));

endmodule

// File: rtl/cpreg_access_unit.sv
// Module: cpreg_access_unit (top)
// Coprocessor system register access decoder. It decodes a move
// instruction, applies the privilege rules and serves the two registers.
// Assumes the core holds req_valid for one cycle per instruction and only
// routes instructions for this coprocessor here.
module cpreg_access_unit
    import cpreg_pkg::*;
#(
    parameter logic [OPC1_W-1:0] MATCH_OPC1 = 3'd6,
    parameter logic [CRN_W-1:0]  CTRL_CRN   = 4'd0,
    parameter logic [CRN_W-1:0]  BASE_CRN   = 4'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               user_mode,
    input  logic               feat_en,
    input  logic [DATA_W-1:0]  wr_value,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [IDX_W-1:0]   rd_index,
    output logic               wr_strobe,
    output logic               undef,
    output logic               ctrl_change
);

    cp_fields_t        fields;
    reg_sel_t          sel;
    logic              rd_ok;
    logic              wr_ctrl;
    logic              wr_base;
    logic              ctrl_q;
    logic [DATA_W-1:0] base_q;

    cpreg_field_decode #(
        .MATCH_OPC1 (MATCH_OPC1),
        .CTRL_CRN   (CTRL_CRN),
        .BASE_CRN   (BASE_CRN)
    ) u_decode (
        .instr  (instr),
        .fields (fields),
        .sel    (sel)
    );

    cpreg_access_check u_check (
        .req_valid (req_valid),
        .feat_en   (feat_en),
        .user_mode (user_mode),
        .is_read   (fields.is_read),
        .sel       (sel),
        .ctrl_bit  (ctrl_q),
        .undef     (undef),
        .rd_ok     (rd_ok),
        .wr_ctrl   (wr_ctrl),
        .wr_base   (wr_base)
    );

    cpreg_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wr_base     (wr_base),
        .wr_value    (wr_value),
        .ctrl_q      (ctrl_q),
        .base_q      (base_q),
        .ctrl_change (ctrl_change)
    );

    // read data mux, zero unless a read is accepted
    always_comb begin
        rd_data  = '0;
        rd_index = '0;
        if (rd_ok) begin
            rd_index = fields.rt;
            if (sel == SEL_CTRL) rd_data = {{(DATA_W-1){1'b0}}, ctrl_q};
            else                 rd_data = base_q;
        end
    end

    assign rd_valid  = rd_ok;
    assign wr_strobe = wr_ctrl || wr_base;

    assert_trap_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!rd_valid && !wr_strobe));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(undef || rd_valid || wr_strobe || ctrl_change));

    assert_pulse_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_change |-> wr_strobe);

    assert_strap_traps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !feat_en) |-> undef);

    assert_user_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && (sel == SEL_CTRL)) |-> undef);

    assert_ctrl_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (sel == SEL_CTRL)) |-> (rd_data[DATA_W-1:1] == '0));

    assert_dir_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_strobe));

endmodule

// File: tb/tb_cpreg_access_unit.sv
`timescale 1ns/1ps
module tb_cpreg_access_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        user_mode = 1'b0;
    logic        feat_en = 1'b1;
    logic [31:0] wr_value = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  rd_index;
    logic        wr_strobe;
    logic        undef;
    logic        ctrl_change;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the stored registers
    logic        m_ctrl = 1'b0;
    logic [31:0] m_base = '0;

    always #2.5 clk = ~clk;

    cpreg_access_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
        .user_mode(user_mode), .feat_en(feat_en), .wr_value(wr_value),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index),
        .wr_strobe(wr_strobe), .undef(undef), .ctrl_change(ctrl_change)
    );

    function automatic logic [31:0] mk(bit rd, logic [2:0] o1, logic [3:0] n,
                                       logic [3:0] t, logic [2:0] o2, logic [3:0] m);
        return {8'hEE, o1, rd, n, t, 4'hE, o2, 1'b1, m};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // one request: drive at falling edge, check before rising edge, update model
    task automatic txn(bit v, logic [31:0] ins, bit usr, bit fe, logic [31:0] wv);
        logic [2:0] o1; logic [3:0] n; logic [3:0] m; logic [2:0] o2;
        bit hc, hb, e_undef, ok, rd, e_rdv, e_wrs, e_pulse;
        logic [31:0] e_rdata; logic [3:0] e_idx; string tag;
        @(negedge clk);
        req_valid = v; instr = ins; user_mode = usr; feat_en = fe; wr_value = wv;
        o1 = ins[23:21]; n = ins[19:16]; o2 = ins[7:5]; m = ins[3:0];
        hc = (o1 == 3'd6) && (n == 4'd0) && (m == 4'd0) && (o2 == 3'd0);
        hb = (o1 == 3'd6) && (n == 4'd1) && (m == 4'd0) && (o2 == 3'd0);
        if (!v)             tag = "R11";
        else if (!fe)       tag = "R7";
        else if (!(hc||hb)) tag = "R3";
        else if (hc)        tag = "R4";
        else                tag = "R5";
        e_undef = v && (!fe || !(hc || hb) || (usr && hc) || (usr && hb && m_ctrl));
        ok      = v && !e_undef;
        rd      = ins[20];
        e_rdv   = ok && rd;
        e_wrs   = ok && !rd;
        e_rdata = !e_rdv ? 32'h0 : (hc ? {31'h0, m_ctrl} : m_base);
        e_idx   = e_rdv ? ins[15:12] : 4'h0;
        e_pulse = e_wrs && hc && (wv[0] != m_ctrl);
        #1;
        chk(tag, "undef", {31'h0, undef}, {31'h0, e_undef});
        chk("R2", "rd_valid", {31'h0, rd_valid}, {31'h0, e_rdv});
        chk("R2", "wr_strobe", {31'h0, wr_strobe}, {31'h0, e_wrs});
        chk(hc ? "R6" : "R9", "rd_data", rd_data, e_rdata);
        chk("R1", "rd_index", {28'h0, rd_index}, {28'h0, e_idx});
        chk("R8", "ctrl_change", {31'h0, ctrl_change}, {31'h0, e_pulse});
        @(posedge clk);
        if (e_wrs && hc) m_ctrl = wv[0];
        if (e_wrs && hb) m_base = wv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10: reset state read back through both registers
        txn(1, mk(1, 3'd6, 4'd0, 4'd3, 3'd0, 4'd0), 0, 1, 32'h0);
        txn(1, mk(1, 3'd6, 4'd1, 4'd7, 3'd0, 4'd0), 0, 1, 32'h0);
        // R8: same-value write gives no pulse; R6 upper bits dropped
        txn(1, mk(0, 3'd6, 4'd0, 4'd2, 3'd0, 4'd0), 0, 1, 32'hFFFF_FFFE);
        txn(1, mk(0, 3'd6, 4'd0, 4'd2, 3'd0, 4'd0), 0, 1, 32'h0000_0003);
        txn(1, mk(1, 3'd6, 4'd0, 4'd9, 3'd0, 4'd0), 0, 1, 32'h0);
        txn(1, mk(0, 3'd6, 4'd0, 4'd2, 3'd0, 4'd0), 0, 1, 32'h0000_0001);
        // R5: user base access traps with control bit set; R11 register unchanged
        txn(1, mk(0, 3'd6, 4'd1, 4'd1, 3'd0, 4'd0), 1, 1, 32'hDEAD_BEEF);
        txn(1, mk(1, 3'd6, 4'd1, 4'd1, 3'd0, 4'd0), 0, 1, 32'h0);
        // privileged base write allowed while control bit set
        txn(1, mk(0, 3'd6, 4'd1, 4'd1, 3'd0, 4'd0), 0, 1, 32'hA5A5_0F0F);
        txn(1, mk(0, 3'd6, 4'd0, 4'd2, 3'd0, 4'd0), 0, 1, 32'h0);
        // R9: user base write and read back with control bit clear
        txn(1, mk(0, 3'd6, 4'd1, 4'd4, 3'd0, 4'd0), 1, 1, 32'h1234_5678);
        txn(1, mk(1, 3'd6, 4'd1, 4'd15, 3'd0, 4'd0), 1, 1, 32'h0);
        // R4: user control access traps both ways
        txn(1, mk(1, 3'd6, 4'd0, 4'd5, 3'd0, 4'd0), 1, 1, 32'h0);
        txn(1, mk(0, 3'd6, 4'd0, 4'd5, 3'd0, 4'd0), 1, 1, 32'h1);
        // R7: strap low traps; R11 trapped write leaves control bit clear
        txn(1, mk(0, 3'd6, 4'd0, 4'd5, 3'd0, 4'd0), 0, 0, 32'h1);
        txn(1, mk(1, 3'd6, 4'd0, 4'd5, 3'd0, 4'd0), 0, 1, 32'h0);
        // R3: near-miss encodings
        txn(1, mk(1, 3'd7, 4'd0, 4'd5, 3'd0, 4'd0), 0, 1, 32'h0);
        txn(1, mk(1, 3'd6, 4'd2, 4'd5, 3'd0, 4'd0), 0, 1, 32'h0);
        txn(1, mk(0, 3'd6, 4'd1, 4'd5, 3'd1, 4'd0), 0, 1, 32'hFFFF_FFFF);
        txn(1, mk(0, 3'd6, 4'd1, 4'd5, 3'd0, 4'd8), 0, 1, 32'hFFFF_FFFF);
        // R11: idle cycle with a write pattern on the bus has no effect
        txn(0, mk(0, 3'd6, 4'd1, 4'd5, 3'd0, 4'd0), 0, 1, 32'hCAFE_F00D);
        txn(1, mk(1, 3'd6, 4'd1, 4'd6, 3'd0, 4'd0), 0, 1, 32'h0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins;
            ins = $urandom;
            if ($urandom % 4 != 0) ins[23:21] = 3'd6;
            if ($urandom % 4 != 0) ins[19:16] = 4'($urandom % 2);
            if ($urandom % 8 != 0) ins[7:5] = 3'd0;
            if ($urandom % 8 != 0) ins[3:0] = 4'd0;
            txn(($urandom % 8) != 0, ins, 1'($urandom % 2),
                ($urandom % 8) != 0, $urandom);
        end
        // R10: synchronous reset clears both registers
        @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        m_ctrl = 1'b0; m_base = '0;
        txn(1, mk(1, 3'd6, 4'd0, 4'd3, 3'd0, 4'd0), 0, 1, 32'h0);
        txn(1, mk(1, 3'd6, 4'd1, 4'd3, 3'd0, 4'd0), 0, 1, 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule